// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for 128 pins, arranged as four banks of 32 pins. Pin `n` belongs to bank `n >> 5` at bit `n % 32`. For each pin, software chooses whether it is an input or an output. Outputs come from an output latch that is never written directly: one register ORs ones into it and another removes the bits written as one. A pin-level register shows what each pin currently carries.

Inputs pass through a two-flop synchronizer. After that, a rising or falling transition on an input pin can latch a sticky status bit, provided that edge direction is enabled for the pin. Software clears status bits by writing ones to them. Pins 0 and 1 each drive their own interrupt line, and all other status bits share a third line. A fixed subset of input pins raises a one-cycle wake request whenever its level changes. Each bank also has two alternate-function words, which are plain storage and have no effect on the block.

The register map is irregular. Banks 0 to 2 of each register kind sit in consecutive words. Bank 3 sits in a second window 0x100 above the bank-0 address of the same kind.

Top module: `banked_gpio`

## Requirements
- R1: After reset, all registers are zero. Every pin is an input, `pinOut` and `pinDir` are 0, all three interrupt lines are low, `wakeReq` is low and `regRdata` is 0.
- R2: A read strobe in one cycle updates `regRdata` at the next clock edge, and `regRdata` holds that value until the next read. Register word addresses are:
  - Banks 0–2 at `base + 4*bank`; bank 3 at `base + 0x100`.
  - Bases: level 0x000, direction 0x00C, set 0x018, clear 0x024, rise enable 0x030, fall enable 0x03C, status 0x048.
- R3: A write to a direction register replaces that bank's direction bits at the clock edge, where 1 means output. `pinDir` shows all 128 bits, and a read returns them.
- R4: A write to the set register ORs the data into the bank's output latch. A write to the clear register removes the bits written as 1. `pinOut` shows the latch ANDed with the direction bits.
- R5: A read of a set register returns the last data written to it. A read of a clear register returns 31337 (decimal).
- R6: A read of a level register returns, per bit, the latch for output pins and the synchronized input for input pins. The synchronized input lags `pinIn` by two clock edges.
- R7: A status bit is set one edge after the synchronized level changes when both of these hold:
  - the pin is an input;
  - the edge direction is enabled (rising: level 0 to 1; falling: level 1 to 0).

  Output pins never set status.
- R8: A status write clears the bits written as 1 and leaves the others. An edge that lands in the same cycle as the clear keeps the bit set.
- R9: `irqPin0` equals status bit 0 of bank 0, and `irqPin1` equals status bit 1 of bank 0. `irqOther` is the OR of every other status bit in all four banks.
- R10: `wakeReq` pulses for one cycle, one edge after the synchronized level changes, when the changing pin is an input and is in its bank's wake mask. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3.
- R11: The alternate-function words are read/write storage with no other effect. The low words are at 0x054/0x05C/0x064/0x06C and the high words at 0x058/0x060/0x068/0x070, for banks 0 to 3.
- R12: Reads of any unmapped or misaligned offset return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 9 | Byte offset of the register access |
| regWdata | input | 32 | Write data |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regRdata | output | 32 | Read data, registered |
| pinIn | input | 128 | Pin input levels (asynchronous) |
| pinOut | output | 128 | Driven pin levels (latch AND direction) |
| pinDir | output | 128 | Pin direction, 1 = output |
| irqPin0 | output | 1 | Status of pin 0 |
| irqPin1 | output | 1 | Status of pin 1 |
| irqOther | output | 1 | OR of all other status bits |
| wakeReq | output | 1 | Wake pulse from a masked input change |

## Verification
The bench drives edges in several situations, and each one separates a different error:
- Rising transitions on input pins with rising detection enabled.
- The same transitions on pins configured as outputs, which shows whether the direction gate works.
- Falling transitions in a bank that has only falling detection enabled, which shows whether the two enables are kept apart.
- An edge timed to land in the same cycle as a write-one clear, which shows which of the two wins.

Level reads are taken with a mixed direction pattern, so a swapped select between latch and input is exposed. Every bank-3 access goes through the upper window, which exposes a wrong window decode. Pins inside and outside the wake masks are toggled to show whether the mask is applied.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_EDGE, K_AFLO, K_AFHI
  } regKind_e;

  // Strobes from the decoder to the datapath; bank index is fixed at 2 bits by the map
  typedef struct packed {
    logic     wr;
    logic     rd;
    regKind_e kind;
    logic [1:0] bank;
  } regStrobe_t;

  localparam logic [31:0] CLR_READ_VALUE = 32'd31337;

  function automatic logic [31:0] wakeMaskFor(input int b);
    case (b)
      0: wakeMaskFor = 32'h8003FE1B;
      1: wakeMaskFor = 32'h002001FC;
      2: wakeMaskFor = 32'hEC080000;
      default: wakeMaskFor = 32'h0012007F;
    endcase
  endfunction

  function automatic regKind_e groupKind(input int g);
    case (g)
      0: groupKind = K_LEVEL;
      1: groupKind = K_DIR;
      2: groupKind = K_SET;
      3: groupKind = K_CLR;
      4: groupKind = K_RISE;
      5: groupKind = K_FALL;
      6: groupKind = K_EDGE;
      default: groupKind = K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrReq,
  input  logic              rdReq,
  output regStrobe_t        strobe
);
  localparam logic [5:0] LOW_GROUP_END = 6'd21;  // 7 kinds x 3 banks
  localparam logic [5:0] AF_END        = 6'd29;  // 8 alternate-function words
  localparam logic [5:0] HIGH_LAST     = 6'd18;  // status word of the upper window

  logic [5:0] word;
  regKind_e   kind;
  logic [1:0] bank;
  logic [5:0] afIdx;

  assign word  = addr[7:2];
  assign afIdx = word - LOW_GROUP_END;

  always_comb begin
    kind = K_NONE;
    bank = 2'd0;
    if (addr[1:0] == 2'b00) begin
      if (!addr[ADDR_W-1]) begin
        if (word < LOW_GROUP_END) begin
          kind = groupKind(int'(word) / 3);
          bank = 2'(int'(word) % 3);
        end else if (word < AF_END) begin
          kind = afIdx[0] ? K_AFHI : K_AFLO;
          bank = afIdx[2:1];
        end
      end else if ((int'(word) % 3 == 0) && (word <= HIGH_LAST)) begin
        kind = groupKind(int'(word) / 3);
        bank = 2'd3;
      end
    end
  end

  assign strobe.wr   = wrReq && (kind != K_NONE);
  assign strobe.rd   = rdReq;
  assign strobe.kind = kind;
  assign strobe.bank = bank;
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_bank_pkg::*;
#(
  parameter int                BANK_W    = 32,
  parameter logic [BANK_W-1:0] WAKE_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHit,
  input  regKind_e          wrKind,
  input  logic [BANK_W-1:0] wrData,
  input  logic [BANK_W-1:0] lvlNow,
  input  logic [BANK_W-1:0] lvlPrev,
  output logic [BANK_W-1:0] dirQ,
  output logic [BANK_W-1:0] outQ,
  output logic [BANK_W-1:0] riseQ,
  output logic [BANK_W-1:0] fallQ,
  output logic [BANK_W-1:0] statQ,
  output logic [BANK_W-1:0] setLastQ,
  output logic [BANK_W-1:0] afLoQ,
  output logic [BANK_W-1:0] afHiQ,
  output logic              wakeHit
);
  logic [BANK_W-1:0] edgeHit;
  logic [BANK_W-1:0] clrMask;

  // only input pins capture edges
  assign edgeHit = ((lvlNow & ~lvlPrev & riseQ) | (~lvlNow & lvlPrev & fallQ)) & ~dirQ;
  assign clrMask = (wrHit && wrKind == K_EDGE) ? wrData : '0;
  assign wakeHit = |((lvlNow ^ lvlPrev) & ~dirQ & WAKE_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '0;
      outQ     <= '0;
      riseQ    <= '0;
      fallQ    <= '0;
      statQ    <= '0;
      setLastQ <= '0;
      afLoQ    <= '0;
      afHiQ    <= '0;
    end else begin
      if (wrHit) begin
        case (wrKind)
          K_DIR:  dirQ  <= wrData;
          K_SET: begin
            outQ     <= outQ | wrData;
            setLastQ <= wrData;
          end
          K_CLR:  outQ  <= outQ & ~wrData;
          K_RISE: riseQ <= wrData;
          K_FALL: fallQ <= wrData;
          K_AFLO: afLoQ <= wrData;
          K_AFHI: afHiQ <= wrData;
          default: ;
        endcase
      end
      // a fresh edge overrides a clear in the same cycle
      statQ <= (statQ & ~clrMask) | edgeHit;
    end
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  localparam int NPINS    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [BANK_W-1:0] wrData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [BANK_W-1:0] rdData,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDir,
  output logic [NPINS-1:0]  statusAll,
  output logic              wakeReq
);
  logic [NPINS-1:0] syncA, syncB, syncC;
  logic [BANK_W-1:0] dirArr [NUM_BANKS];
  logic [BANK_W-1:0] outArr [NUM_BANKS];
  logic [BANK_W-1:0] riseArr [NUM_BANKS];
  logic [BANK_W-1:0] fallArr [NUM_BANKS];
  logic [BANK_W-1:0] statArr [NUM_BANKS];
  logic [BANK_W-1:0] setArr [NUM_BANKS];
  logic [BANK_W-1:0] afLoArr [NUM_BANKS];
  logic [BANK_W-1:0] afHiArr [NUM_BANKS];
  logic [BANK_W-1:0] levelArr [NUM_BANKS];
  logic [NUM_BANKS-1:0] wakeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_slice #(
      .BANK_W   (BANK_W),
      .WAKE_MASK(BANK_W'(wakeMaskFor(b)))
    ) u_slice (
      .clk     (clk),
      .rstN    (rstN),
      .wrHit   (strobe.wr && (int'(strobe.bank) == b)),
      .wrKind  (strobe.kind),
      .wrData  (wrData),
      .lvlNow  (syncB[b*BANK_W +: BANK_W]),
      .lvlPrev (syncC[b*BANK_W +: BANK_W]),
      .dirQ    (dirArr[b]),
      .outQ    (outArr[b]),
      .riseQ   (riseArr[b]),
      .fallQ   (fallArr[b]),
      .statQ   (statArr[b]),
      .setLastQ(setArr[b]),
      .afLoQ   (afLoArr[b]),
      .afHiQ   (afHiArr[b]),
      .wakeHit (wakeVec[b])
    );
    assign levelArr[b] = (outArr[b] & dirArr[b]) | (syncB[b*BANK_W +: BANK_W] & ~dirArr[b]);
    assign pinDir[b*BANK_W +: BANK_W]    = dirArr[b];
    assign pinOut[b*BANK_W +: BANK_W]    = outArr[b] & dirArr[b];
    assign statusAll[b*BANK_W +: BANK_W] = statArr[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      wakeReq <= 1'b0;
    end else begin
      wakeReq <= |wakeVec;
      if (strobe.rd) begin
        case (strobe.kind)
          K_LEVEL: rdData <= levelArr[strobe.bank];
          K_DIR:   rdData <= dirArr[strobe.bank];
          K_SET:   rdData <= setArr[strobe.bank];
          K_CLR:   rdData <= BANK_W'(CLR_READ_VALUE);
          K_RISE:  rdData <= riseArr[strobe.bank];
          K_FALL:  rdData <= fallArr[strobe.bank];
          K_EDGE:  rdData <= statArr[strobe.bank];
          K_AFLO:  rdData <= afLoArr[strobe.bank];
          K_AFHI:  rdData <= afHiArr[strobe.bank];
          default: rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 9,
  localparam int NPINS    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BANK_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [BANK_W-1:0] regRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDir,
  output logic              irqPin0,
  output logic              irqPin1,
  output logic              irqOther,
  output logic              wakeReq
);
  regStrobe_t       strobe;
  logic [NPINS-1:0] statusAll;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (regAddr),
    .wrReq (regWr),
    .rdReq (regRd),
    .strobe(strobe)
  );

  gpio_bank_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWdata),
    .pinIn    (pinIn),
    .rdData   (regRdata),
    .pinOut   (pinOut),
    .pinDir   (pinDir),
    .statusAll(statusAll),
    .wakeReq  (wakeReq)
  );

  assign irqPin0  = statusAll[0];
  assign irqPin1  = statusAll[1];
  assign irqOther = |statusAll[NPINS-1:2];
endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk #(
  parameter int NPINS = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic [8:0]       regAddr,
  input logic [31:0]      regWdata,
  input logic             regWr,
  input logic             regRd,
  input logic [31:0]      regRdata,
  input logic [NPINS-1:0] pinOut,
  input logic [NPINS-1:0] pinDir,
  input logic             irqPin0
);
  // R1
  reset_clears_dir_chk: assert property (@(posedge clk)
    !rstN |=> (pinDir == '0 && pinOut == '0));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 9'h00C) |=> (pinDir[31:0] == $past(regWdata)));

  // R4
  set_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 9'h018) |=>
      ((pinOut[31:0] & $past(regWdata)) == ($past(regWdata) & pinDir[31:0])));

  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 9'h024) |=> ((pinOut[31:0] & $past(regWdata)) == 32'h0));

  // R5
  clr_read_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 9'h024) |=> (regRdata == 32'd31337));

  // R7
  irq_from_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPin0) |-> $past(!pinDir[0]));

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 9'h1FC) |=> (regRdata == 32'h0));
endmodule

bind banked_gpio banked_gpio_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regWr   (regWr),
  .regRd   (regRd),
  .regRdata(regRdata),
  .pinOut  (pinOut),
  .pinDir  (pinDir),
  .irqPin0 (irqPin0)
);

// File: tb/banked_gpio_bench.sv
`timescale 1ns/1ps
module banked_gpio_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [8:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic         regWr = 1'b0;
  logic         regRd = 1'b0;
  logic [31:0]  regRdata;
  logic [127:0] pinIn = '0;
  logic [127:0] pinOut, pinDir;
  logic         irqPin0, irqPin1, irqOther, wakeReq;

  always #4 clk = ~clk;  // 125 MHz

  banked_gpio u_banked_gpio (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .irqPin0(irqPin0), .irqPin1(irqPin1),
    .irqOther(irqOther), .wakeReq(wakeReq)
  );

  // reference state
  logic [127:0] mDir, mOut, mRise, mFall, mStat, mSetLast, mAfLo, mAfHi;
  logic [127:0] m1, m2, m3;
  logic [31:0]  mRdata;
  logic         mWake;
  logic [127:0] wakeAll = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};
  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit finished = 0;

  // kinds: 1 level,2 dir,3 set,4 clr,5 rise,6 fall,7 status,8 af-low,9 af-high
  task automatic refDecode(input logic [8:0] a, output int kind, output int bank);
    int bases[7] = '{'h000, 'h00C, 'h018, 'h024, 'h030, 'h03C, 'h048};
    kind = 0; bank = 0;
    for (int g = 0; g < 7; g++)
      for (int b = 0; b < 4; b++)
        if (int'(a) == bases[g] + ((b < 3) ? 4 * b : 'h100)) begin kind = g + 1; bank = b; end
    for (int b = 0; b < 4; b++) begin
      if (int'(a) == 'h054 + 8 * b) begin kind = 8; bank = b; end
      if (int'(a) == 'h058 + 8 * b) begin kind = 9; bank = b; end
    end
  endtask

  task automatic check(input string what, input logic [127:0] got, input logic [127:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", curReq, what, got, exp);
    end
  endtask

  task automatic tick();
    int kind, bank;
    logic [127:0] edgeV, lvl, clrM, wmask;
    @(posedge clk);
    if (!rstN) begin
      mDir = '0; mOut = '0; mRise = '0; mFall = '0; mStat = '0; mSetLast = '0;
      mAfLo = '0; mAfHi = '0; m1 = '0; m2 = '0; m3 = '0; mRdata = '0; mWake = 0;
    end else begin
      edgeV = ((m2 & ~m3 & mRise) | (~m2 & m3 & mFall)) & ~mDir;
      mWake = |((m2 ^ m3) & ~mDir & wakeAll);
      lvl = (mOut & mDir) | (m2 & ~mDir);
      refDecode(regAddr, kind, bank);
      if (regRd) begin
        case (kind)
          1: mRdata = lvl[bank*32 +: 32];
          2: mRdata = mDir[bank*32 +: 32];
          3: mRdata = mSetLast[bank*32 +: 32];
          4: mRdata = 32'd31337;
          5: mRdata = mRise[bank*32 +: 32];
          6: mRdata = mFall[bank*32 +: 32];
          7: mRdata = mStat[bank*32 +: 32];
          8: mRdata = mAfLo[bank*32 +: 32];
          9: mRdata = mAfHi[bank*32 +: 32];
          default: mRdata = 0;
        endcase
      end
      clrM = '0;
      wmask = 128'hFFFF_FFFF << (bank * 32);
      if (regWr) begin
        case (kind)
          2: mDir = (mDir & ~wmask) | (128'(regWdata) << (bank * 32));
          3: begin
               mOut = mOut | (128'(regWdata) << (bank * 32));
               mSetLast = (mSetLast & ~wmask) | (128'(regWdata) << (bank * 32));
             end
          4: mOut = mOut & ~(128'(regWdata) << (bank * 32));
          5: mRise = (mRise & ~wmask) | (128'(regWdata) << (bank * 32));
          6: mFall = (mFall & ~wmask) | (128'(regWdata) << (bank * 32));
          7: clrM = 128'(regWdata) << (bank * 32);
          8: mAfLo = (mAfLo & ~wmask) | (128'(regWdata) << (bank * 32));
          9: mAfHi = (mAfHi & ~wmask) | (128'(regWdata) << (bank * 32));
          default: ;
        endcase
      end
      mStat = (mStat & ~clrM) | edgeV;
      m3 = m2; m2 = m1; m1 = pinIn;
    end
    @(negedge clk);
    check("pinDir", pinDir, mDir);
    check("pinOut", pinOut, mOut & mDir);
    check("irqPin0 (R9)", 128'(irqPin0), 128'(mStat[0]));
    check("irqPin1 (R9)", 128'(irqPin1), 128'(mStat[1]));
    check("irqOther (R9)", 128'(irqOther), 128'(|mStat[127:2]));
    check("wakeReq", 128'(wakeReq), 128'(mWake));
    check("regRdata", 128'(regRdata), 128'(mRdata));
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    tick();
    regWr = 1'b0;
  endtask

  task automatic doRead(input logic [8:0] a);
    regAddr = a; regRd = 1'b1;
    tick();
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    idle(2);
    doRead(9'h000);

    curReq = "R3";
    doWrite(9'h00C, 32'h0000_00F0);
    doWrite(9'h10C, 32'hFFFF_0000);
    doRead(9'h00C);
    curReq = "R2";
    doRead(9'h10C);
    idle(1);  // regRdata must hold

    curReq = "R4";
    doWrite(9'h018, 32'h0000_00FF);
    doWrite(9'h024, 32'h0000_0030);
    doWrite(9'h118, 32'h00FF_FF00);
    doWrite(9'h124, 32'h000F_0000);

    curReq = "R5";
    doRead(9'h018);
    doRead(9'h118);
    doRead(9'h024);

    curReq = "R6";
    pinIn = {32'hA5A5_5A5A, 32'h1234_5678, 32'h0F0F_F0F0, 32'hDEAD_BEEF};
    idle(3);
    doRead(9'h000);
    doRead(9'h004);
    doRead(9'h100);

    curReq = "R7";
    pinIn = '0;
    idle(4);
    doWrite(9'h030, 32'hFFFF_FFFF);
    doWrite(9'h040, 32'hFFFF_FFFF);
    doWrite(9'h048, 32'hFFFF_FFFF);
    doWrite(9'h04C, 32'hFFFF_FFFF);
    pinIn[7:4] = 4'hF;  // output pins: no capture
    idle(4);
    doRead(9'h048);
    pinIn[40] = 1'b1;   // bank1 rise disabled
    idle(4);
    doRead(9'h04C);
    curReq = "R9";
    pinIn[40] = 1'b0;   // bank1 falling enabled
    idle(4);
    doRead(9'h04C);
    pinIn[1:0] = 2'b11;
    idle(4);
    doRead(9'h048);

    curReq = "R8";
    doWrite(9'h048, 32'h0000_0002);
    pinIn[0] = 1'b0;  // bank0 falling disabled
    idle(4);
    pinIn[0] = 1'b1;
    tick(); tick();
    doWrite(9'h048, 32'h0000_0001);  // edge lands with clear
    doRead(9'h048);
    doWrite(9'h048, 32'h0000_0001);
    doWrite(9'h04C, 32'h0000_0100);
    doRead(9'h048);

    curReq = "R10";
    pinIn[2] = 1'b1;   // not in mask
    idle(4);
    pinIn[3] = 1'b1;   // in mask
    idle(4);
    pinIn[127] = 1'b1; // bank3 bit31 not in mask
    idle(4);
    pinIn[116] = 1'b1; // bank3 bit20 in mask
    idle(4);

    curReq = "R11";
    doWrite(9'h054, 32'hCAFE_0001);
    doWrite(9'h070, 32'hBEEF_0002);
    doRead(9'h054);
    doRead(9'h070);
    doRead(9'h058);

    curReq = "R12";
    doWrite(9'h074, 32'hFFFF_FFFF);
    doWrite(9'h1F0, 32'hFFFF_FFFF);
    doWrite(9'h00E, 32'hFFFF_FFFF);
    doRead(9'h074);
    doRead(9'h1FC);
    doRead(9'h002);
    doRead(9'h00C);
    idle(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog %s: got hang expected finish", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule